// File: doc/BRIEF.md
# I2C Receive Data Pattern Matcher

This block sits beside the receive path of an I2C controller and inspects every byte that the controller hands over. It compares the byte stream against a pattern built from two byte-wide match values, and it sets a sticky match flag when the pattern is seen. The pattern can be a single byte equal to either value, a two-byte sequence, or a masked comparison in which the second value selects the bits that must agree with the first. Each kind can be restricted to the first word of a frame or allowed at any word position.

A start or repeated start strobe marks a new frame and clears the position and sequence trackers. Software clears the flag by writing one to it, and an enable gates the flag onto an interrupt request. For each received byte the block also tells the receive FIFO whether to keep the byte. Normally every byte is kept. In match-only mode, bytes are dropped until a match has been seen, and the byte that completes the match is kept.

Top module: `rx_pattern_matcher`

## Requirements
- R1: After reset, `match_flag` and `irq` are 0.
- R2: Mode codes 0 and 1 never set the flag, whatever bytes arrive.
- R3: Mode 2 sets the flag when the first byte of a frame equals `match_val0` or `match_val1`. A later byte equal to either value has no effect.
- R4: Mode 3 sets the flag when any byte of a frame equals `match_val0` or `match_val1`.
- R5: Mode 4 sets the flag only when the first byte equals `match_val0` and the second byte equals `match_val1`.
- R6: Mode 5 sets the flag when a byte equal to `match_val0` is immediately followed, within the same frame, by a byte equal to `match_val1`.
- R7: Mode 6 sets the flag when (first byte AND `match_val1`) equals (`match_val0` AND `match_val1`).
- R8: Mode 7 applies the masked comparison of R7 to every byte of the frame.
- R9: The flag rises on the clock edge that accepts the completing byte. It stays set until `flag_clr` is high at a clock edge. When a new match and `flag_clr` meet on the same edge, the flag stays set.
- R10: `irq` is high exactly when the flag is set and `irq_en` is high.
- R11: With `match_only_rx` low, `store_byte` follows `rx_valid`. With `match_only_rx` high, `store_byte` is high for a valid byte only if the flag is already set or that byte completes a match.
- R12: A high `frame_start` restarts word counting and the pair tracker. A byte accepted in the same cycle as `frame_start` counts as the first byte of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is presented this cycle |
| rx_byte | input | DATA_W | Received byte |
| frame_start | input | 1 | Start or repeated start seen on the bus |
| match_mode | input | 3 | Pattern kind, codes 0 to 7 |
| match_val0 | input | DATA_W | First match value |
| match_val1 | input | DATA_W | Second match value, or the mask in masked modes |
| match_only_rx | input | 1 | Drop bytes until a match is seen |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| match_flag | output | 1 | Sticky data-match flag |
| irq | output | 1 | Interrupt request |
| store_byte | output | 1 | Keep the current byte in the receive FIFO |

## Verification
`store_byte` is combinational and is due in the same cycle as the byte it judges. The bench therefore samples it one time unit after driving the byte, before the clock edge. `match_flag` and `irq` move on the edge that accepts the byte, so the bench samples them at the falling edge that follows. Because every input is driven at a falling edge and held for exactly one cycle, each sample falls in a known cycle. The checks for persistence sample again after idle cycles, and the checks for clearing sample on the falling edge just after the `flag_clr` pulse.

// File: rtl/rxpm_pkg.sv
package rxpm_pkg;

    typedef enum logic [2:0] {
        MM_OFF        = 3'd0,
        MM_RSVD       = 3'd1,
        MM_FIRST_EQ   = 3'd2,
        MM_ANY_EQ     = 3'd3,
        MM_FIRST_PAIR = 3'd4,
        MM_ANY_PAIR   = 3'd5,
        MM_FIRST_MASK = 3'd6,
        MM_ANY_MASK   = 3'd7
    } match_mode_e;

    // Position of the current byte within its frame.
    typedef struct packed {
        logic first;      // byte is word 0 of the frame
        logic second;     // byte is word 1 of the frame
        logic prev_hit0;  // previous byte of this frame equalled value 0
    } word_pos_t;

    localparam int unsigned POS_CNT_W = 2;
    localparam logic [POS_CNT_W-1:0] POS_SAT = 2'd2;

    function automatic logic mode_first_only(match_mode_e m);
        return (m == MM_FIRST_EQ) || (m == MM_FIRST_MASK);
    endfunction

endpackage

// File: rtl/rxpm_word_tracker.sv
module rxpm_word_tracker
    import rxpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_valid,
    input  logic      frame_start,
    input  logic      byte_eq0,
    output word_pos_t pos
);
    logic [POS_CNT_W-1:0] cnt_q, cnt_eff;
    logic                 prev_q, prev_eff;

    // A start in this cycle makes the current byte word 0.
    always_comb begin
        cnt_eff  = frame_start ? '0 : cnt_q;
        prev_eff = frame_start ? 1'b0 : prev_q;
        pos.first     = (cnt_eff == '0);
        pos.second    = (cnt_eff == POS_CNT_W'(1));
        pos.prev_hit0 = prev_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else if (rx_valid) begin
            cnt_q  <= (cnt_eff == POS_SAT) ? POS_SAT : cnt_eff + POS_CNT_W'(1);
            prev_q <= byte_eq0;
        end else if (frame_start) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxpm_compare.sv
module rxpm_compare
    import rxpm_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] val0,
    input  logic [DATA_W-1:0] val1,
    input  match_mode_e       mode,
    input  word_pos_t         pos,
    output logic              byte_eq0,
    output logic              hit
);
    logic eq1, masked, raw;

    always_comb begin
        byte_eq0 = (rx_byte == val0);
        eq1      = (rx_byte == val1);
        masked   = ((rx_byte & val1) == (val0 & val1));
        unique case (mode)
            MM_FIRST_EQ, MM_ANY_EQ:     raw = byte_eq0 | eq1;
            MM_FIRST_PAIR:              raw = pos.second & pos.prev_hit0 & eq1;
            MM_ANY_PAIR:                raw = pos.prev_hit0 & eq1;
            MM_FIRST_MASK, MM_ANY_MASK: raw = masked;
            default:                    raw = 1'b0;
        endcase
        if (mode_first_only(mode) && !pos.first) raw = 1'b0;
        hit = rx_valid & raw;
    end
endmodule

// File: rtl/rxpm_flag.sv
module rxpm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/rx_pattern_matcher.sv
module rx_pattern_matcher
    import rxpm_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              frame_start,
    input  logic [2:0]        match_mode,
    input  logic [DATA_W-1:0] match_val0,
    input  logic [DATA_W-1:0] match_val1,
    input  logic              match_only_rx,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              match_flag,
    output logic              irq,
    output logic              store_byte
);
    word_pos_t   pos;
    logic        byte_eq0, hit;
    match_mode_e mode;

    assign mode = match_mode_e'(match_mode);

    rxpm_word_tracker u_track (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .frame_start(frame_start),
        .byte_eq0(byte_eq0), .pos(pos)
    );

    rxpm_compare #(.DATA_W(DATA_W)) u_cmp (
        .rx_byte(rx_byte), .rx_valid(rx_valid), .val0(match_val0), .val1(match_val1),
        .mode(mode), .pos(pos), .byte_eq0(byte_eq0), .hit(hit)
    );

    rxpm_flag u_flag (
        .clk(clk), .rst(rst), .set(hit), .clr(flag_clr), .flag(match_flag)
    );

    assign irq        = match_flag & irq_en;
    assign store_byte = rx_valid & (~match_only_rx | match_flag | hit);
endmodule

// File: rtl/rxpm_checker.sv
module rxpm_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic [2:0] match_mode,
    input logic       match_only_rx,
    input logic       irq_en,
    input logic       flag_clr,
    input logic       match_flag,
    input logic       irq,
    input logic       store_byte
);
    a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> !match_flag);

    a_r2_off_modes_quiet: assert property (@(posedge clk) disable iff (rst)
        (!match_flag && (!rx_valid || match_mode <= 3'd1)) |=> !match_flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !flag_clr) |=> match_flag);

    a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !rx_valid) |=> !match_flag);

    a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> (match_flag && irq_en));

    a_r11_store_all: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !match_only_rx) |-> store_byte);

    a_r11_store_needs_valid: assert property (@(posedge clk) disable iff (rst)
        store_byte |-> rx_valid);
endmodule

bind rx_pattern_matcher rxpm_checker chk_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .match_mode(match_mode),
    .match_only_rx(match_only_rx), .irq_en(irq_en), .flag_clr(flag_clr),
    .match_flag(match_flag), .irq(irq), .store_byte(store_byte)
);

// File: tb/rx_pattern_matcher_tb_top.sv
module rx_pattern_matcher_tb_top;
    typedef struct packed {
        logic [2:0] mode;
        logic [7:0] m0;
        logic [7:0] m1;
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
        logic       exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 1'b0},  // R2 off
        '{3'd1, 8'h55, 8'h55, 8'h55, 8'h55, 8'h55, 1'b0},  // R2 reserved
        '{3'd2, 8'hA5, 8'h3C, 8'h3C, 8'h00, 8'h00, 1'b1},  // R3 first word hits
        '{3'd2, 8'hA5, 8'h3C, 8'h00, 8'hA5, 8'h00, 1'b0},  // R3 later word ignored
        '{3'd3, 8'hA5, 8'h3C, 8'h00, 8'h11, 8'hA5, 1'b1},  // R4 third word hits
        '{3'd3, 8'hA5, 8'h3C, 8'h00, 8'h11, 8'h22, 1'b0},  // R4 no hit
        '{3'd4, 8'h12, 8'h34, 8'h12, 8'h34, 8'h00, 1'b1},  // R5 pair at start
        '{3'd4, 8'h12, 8'h34, 8'h00, 8'h12, 8'h34, 1'b0},  // R5 pair not at start
        '{3'd4, 8'h12, 8'h34, 8'h12, 8'h12, 8'h34, 1'b0},  // R5 second word wrong
        '{3'd5, 8'h12, 8'h34, 8'h00, 8'h12, 8'h34, 1'b1},  // R6 pair mid-frame
        '{3'd5, 8'h12, 8'h34, 8'h12, 8'h00, 8'h34, 1'b0},  // R6 not adjacent
        '{3'd6, 8'h0A, 8'h0F, 8'h5A, 8'h00, 8'h00, 1'b1},  // R7 masked first
        '{3'd6, 8'h0A, 8'h0F, 8'h00, 8'h5A, 8'h00, 1'b0},  // R7 later ignored
        '{3'd7, 8'h80, 8'hF0, 8'h00, 8'h11, 8'h8F, 1'b1},  // R8 masked any
        '{3'd7, 8'h80, 8'hF0, 8'h00, 8'h11, 8'h7F, 1'b0}   // R8 no hit
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid = 1'b0, frame_start = 1'b0, match_only_rx = 1'b0;
    logic       irq_en = 1'b0, flag_clr = 1'b0;
    logic [7:0] rx_byte = '0, match_val0 = '0, match_val1 = '0;
    logic [2:0] match_mode = '0;
    logic       match_flag, irq, store_byte;
    logic       last_store;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rx_pattern_matcher dut_i (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_start(frame_start), .match_mode(match_mode), .match_val0(match_val0),
        .match_val1(match_val1), .match_only_rx(match_only_rx), .irq_en(irq_en),
        .flag_clr(flag_clr), .match_flag(match_flag), .irq(irq), .store_byte(store_byte)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // Starts and ends at a falling edge; inputs held for one cycle.
    task automatic step(input logic v, input logic [7:0] b, input logic fs, input logic clr);
        rx_valid = v; rx_byte = b; frame_start = fs; flag_clr = clr;
        #1 last_store = store_byte;
        @(negedge clk);
        rx_valid = 1'b0; frame_start = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic setup(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b);
        match_mode = m; match_val0 = a; match_val1 = b;
        step(1'b0, 8'h00, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(match_flag, 1'b0, "R1 flag after reset");
        check(irq, 1'b0, "R1 irq after reset");

        irq_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            setup(TBL[i].mode, TBL[i].m0, TBL[i].m1);
            step(1'b1, TBL[i].b0, 1'b0, 1'b0);
            step(1'b1, TBL[i].b1, 1'b0, 1'b0);
            step(1'b1, TBL[i].b2, 1'b0, 1'b0);
            check(match_flag, TBL[i].exp, $sformatf("table row %0d mode %0d flag", i, TBL[i].mode));
            check(irq, TBL[i].exp, $sformatf("R10 table row %0d irq", i));
        end

        // R9: flag rises on the accepting edge, holds, then clears
        setup(3'd3, 8'hAA, 8'hBB);
        step(1'b1, 8'hAA, 1'b0, 1'b0);
        check(match_flag, 1'b1, "R9 flag on accepting edge");
        repeat (5) step(1'b0, 8'h00, 1'b0, 1'b0);
        check(match_flag, 1'b1, "R9 flag held while idle");
        irq_en = 1'b0;
        #1 check(irq, 1'b0, "R10 irq masked by enable");
        irq_en = 1'b1;
        #1 check(irq, 1'b1, "R10 irq follows enable");
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check(match_flag, 1'b0, "R9 clear strobe");
        step(1'b1, 8'hBB, 1'b0, 1'b1);
        check(match_flag, 1'b1, "R9 set wins over clear");

        // R11: store decision
        setup(3'd3, 8'hAA, 8'hBB);
        match_only_rx = 1'b1;
        step(1'b1, 8'h11, 1'b0, 1'b0);
        check(last_store, 1'b0, "R11 drop before match");
        check(match_flag, 1'b0, "R11 no flag from non-match");
        step(1'b1, 8'hAA, 1'b0, 1'b0);
        check(last_store, 1'b1, "R11 completing byte kept");
        step(1'b1, 8'h22, 1'b0, 1'b0);
        check(last_store, 1'b1, "R11 kept after flag set");
        step(1'b0, 8'h00, 1'b0, 1'b1);
        match_only_rx = 1'b0;
        step(1'b1, 8'h11, 1'b0, 1'b0);
        check(last_store, 1'b1, "R11 keep all when mode off");

        // R12: byte with frame_start counts as first word
        setup(3'd2, 8'hA5, 8'h3C);
        step(1'b1, 8'h00, 1'b0, 1'b0);
        step(1'b1, 8'h3C, 1'b1, 1'b0);
        check(match_flag, 1'b1, "R12 byte with start is first word");
        // R12: repeated start breaks a pair
        setup(3'd5, 8'h12, 8'h34);
        step(1'b1, 8'h12, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h34, 1'b0, 1'b0);
        check(match_flag, 1'b0, "R12 repeated start resets pair tracker");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule